// File: doc/BRIEF.md
# Signal Quality Indicator Generator

This block turns a stream of mean-squared-error samples from a receiver's decision logic into one status bit. Each valid sample is compared with one of four thresholds picked by a 2-bit select. While the error stays under the threshold, the bit stays low. Once the error reaches or exceeds the threshold, the bit starts a periodic square wave. Each level of that wave lasts a fixed time, 1.66 ms by default, counted in clock cycles. When the receiver reports that it has lost convergence, the bit is forced high and stays high.

The indicator has meaning only in the phase/amplitude modulation modes (QAM and DPSK). In the frequency-shift mode the bit is held low and samples are ignored. When the convergence-lost flag is cleared at the end of a retrain, the block drops the bit low and resumes normal comparison.

The bit is registered, so every output change appears one clock after the input that causes it.

Top module: `sig_quality_ind`

## Requirements
- R1: After reset is released, the indicator `sq_bad` is low, and it stays low until a qualifying sample or flag arrives.
- R2: In QAM/DPSK mode (`qam_dpsk`=1), with `conv_lost` low, a valid sample below the selected threshold drives `sq_bad` low on the next cycle. It also restarts the toggle timing, so a later crossing starts a fresh high level.
- R3: The threshold select `thr_sel` picks the threshold as follows: 01 picks `THR_E6` (strictest, smallest MSE), 00 picks `THR_E5` (the default), 10 picks `THR_E4`, and 11 picks `THR_E3` (most lenient). A sample equal to the selected threshold counts as crossing it.
- R4: A valid sample at or above the threshold, arriving while the block is not already degraded, drives `sq_bad` high on the next cycle.
- R5: While degraded, `sq_bad` inverts every `CLK_KHZ*TOGGLE_US/1000` cycles, with the first inversion that many cycles after the crossing. Further samples at or above the threshold do not restart this timing.
- R6: In QAM/DPSK mode, an asserted `conv_lost` drives `sq_bad` high on the next cycle and holds it high for as long as the flag stays set, whatever the samples are.
- R7: After `conv_lost` is cleared, `sq_bad` is low on the next cycle. Toggling resumes only after a new valid sample at or above the threshold.
- R8: In FSK mode (`qam_dpsk`=0), `sq_bad` is low on the next cycle, and samples and `conv_lost` have no effect. On return to QAM/DPSK mode the block starts as not degraded.
- R9: A sample presented while `mse_valid` is low is ignored: the output keeps its current level or toggle timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mse | input | W | Mean-squared-error sample |
| mse_valid | input | 1 | Sample strobe |
| thr_sel | input | 2 | Threshold select |
| qam_dpsk | input | 1 | 1 = QAM/DPSK mode, 0 = FSK mode |
| conv_lost | input | 1 | Receiver lost convergence |
| sq_bad | output | 1 | Signal quality indicator |

## Verification
The hardest situation to reach from the ports is a change of state partway through a toggle level. Examples are a good sample that arrives mid-level, or a convergence loss that is cleared while the block is degraded, followed by a fresh crossing that must restart from a full high level. The bench shrinks the toggle period to six cycles so that random sample bursts often land at every counter phase. The random stimulus keeps `mse_valid` sparse and weights `conv_lost` and mode changes lightly, so that degraded runs last long enough to toggle. Directed sequences then cross each threshold at exactly its value and one below it, and clear `conv_lost` while the block is degraded.

// File: rtl/sig_quality_ind.sv
module sig_quality_ind #(
  parameter int unsigned W         = 16,
  parameter logic [W-1:0] THR_E5   = 16'h0200,
  parameter logic [W-1:0] THR_E6   = 16'h0100,
  parameter logic [W-1:0] THR_E4   = 16'h0400,
  parameter logic [W-1:0] THR_E3   = 16'h0800,
  parameter int unsigned CLK_KHZ   = 125000,
  parameter int unsigned TOGGLE_US = 1660
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] mse,
  input  logic         mse_valid,
  input  logic [1:0]   thr_sel,
  input  logic         qam_dpsk,
  input  logic         conv_lost,
  output logic         sq_bad
);
  localparam int unsigned TICKS = CLK_KHZ * TOGGLE_US / 1000;
  localparam int unsigned CW    = (TICKS > 2) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [W-1:0]  thr;
  logic          over;
  logic          degraded;
  logic [CW-1:0] cnt;
  logic          sq_q;

  always_comb begin
    unique case (thr_sel)
      2'b00: thr = THR_E5;
      2'b01: thr = THR_E6;
      2'b10: thr = THR_E4;
      default: thr = THR_E3;
    endcase
  end

  assign over   = (mse >= thr);
  assign sq_bad = sq_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !qam_dpsk) begin
      sq_q     <= 1'b0;
      degraded <= 1'b0;
      cnt      <= '0;
    end else if (conv_lost) begin
      sq_q     <= 1'b1;
      degraded <= 1'b0;
      cnt      <= '0;
    end else if (mse_valid && !over) begin
      sq_q     <= 1'b0;
      degraded <= 1'b0;
      cnt      <= '0;
    end else if (mse_valid && !degraded) begin
      sq_q     <= 1'b1;
      degraded <= 1'b1;
      cnt      <= '0;
    end else if (degraded) begin
      if (cnt == LAST) begin
        cnt  <= '0;
        sq_q <= ~sq_q;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else begin
      sq_q <= 1'b0;
    end
  end
endmodule

module sqi_checker #(
  parameter int unsigned W       = 16,
  parameter logic [W-1:0] THR_E5 = 16'h0200,
  parameter logic [W-1:0] THR_E6 = 16'h0100,
  parameter logic [W-1:0] THR_E4 = 16'h0400,
  parameter logic [W-1:0] THR_E3 = 16'h0800
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] mse,
  input logic         mse_valid,
  input logic [1:0]   thr_sel,
  input logic         qam_dpsk,
  input logic         conv_lost,
  input logic         degraded,
  input logic         sq_bad
);
  logic [W-1:0] ref_thr;
  assign ref_thr = thr_sel[1] ? (thr_sel[0] ? THR_E3 : THR_E4)
                              : (thr_sel[0] ? THR_E6 : THR_E5);

  p_fsk_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !qam_dpsk |=> !sq_bad);

  p_conv_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    qam_dpsk && conv_lost |=> sq_bad);

  p_good_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    qam_dpsk && !conv_lost && mse_valid && (mse < ref_thr) |=> !sq_bad);

  p_enter_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    qam_dpsk && !conv_lost && mse_valid && (mse >= ref_thr) && !degraded
    |=> sq_bad);

  p_retrain_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    qam_dpsk && !conv_lost && $past(conv_lost) && !mse_valid |=> !sq_bad);

  p_idle_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
    qam_dpsk && !conv_lost && !mse_valid && !degraded && !sq_bad |=> !sq_bad);
endmodule

bind sig_quality_ind sqi_checker #(
  .W(W), .THR_E5(THR_E5), .THR_E6(THR_E6), .THR_E4(THR_E4), .THR_E3(THR_E3)
) i_sqi_checker (
  .clk(clk), .rst_n(rst_n), .mse(mse), .mse_valid(mse_valid),
  .thr_sel(thr_sel), .qam_dpsk(qam_dpsk), .conv_lost(conv_lost),
  .degraded(degraded), .sq_bad(sq_bad)
);

// File: tb/test_sig_quality_ind.sv
module test_sig_quality_ind;
  localparam int W = 16;
  localparam logic [W-1:0] T5 = 16'h0200, T6 = 16'h0100, T4 = 16'h0400, T3 = 16'h0800;
  localparam int TICKS = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] mse = '0;
  logic         mse_valid = 1'b0;
  logic [1:0]   thr_sel = 2'b00;
  logic         qam_dpsk = 1'b1;
  logic         conv_lost = 1'b0;
  logic         sq_bad;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  bit m_sq, m_deg;
  int m_cnt;

  always #4 clk = ~clk;

  sig_quality_ind #(.W(W), .THR_E5(T5), .THR_E6(T6), .THR_E4(T4), .THR_E3(T3),
                    .CLK_KHZ(1000), .TOGGLE_US(TICKS)) i_sig_quality_ind (
    .clk(clk), .rst_n(rst_n), .mse(mse), .mse_valid(mse_valid),
    .thr_sel(thr_sel), .qam_dpsk(qam_dpsk), .conv_lost(conv_lost), .sq_bad(sq_bad));

  function automatic logic [W-1:0] thr_of(input logic [1:0] s);
    case (s)
      2'b00: return T5;
      2'b01: return T6;
      2'b10: return T4;
      default: return T3;
    endcase
  endfunction

  task automatic model_edge();
    if (!rst_n || !qam_dpsk) begin m_sq = 0; m_deg = 0; m_cnt = 0; end
    else if (conv_lost) begin m_sq = 1; m_deg = 0; m_cnt = 0; end
    else if (mse_valid && mse < thr_of(thr_sel)) begin m_sq = 0; m_deg = 0; m_cnt = 0; end
    else if (mse_valid && !m_deg) begin m_sq = 1; m_deg = 1; m_cnt = 0; end
    else if (m_deg) begin
      m_cnt++;
      if (m_cnt == TICKS) begin m_cnt = 0; m_sq = !m_sq; end
    end else m_sq = 0;
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    checks++;
    if (sq_bad !== m_sq) begin
      failures++;
      $display("FAIL %s: sq_bad=%0b expected=%0b at cycle %0d", tag, sq_bad, m_sq, cycles);
    end
  endtask

  task automatic drive(input logic v, input logic [W-1:0] s, input logic [1:0] sel,
                       input logic md, input logic cl);
    mse_valid = v; mse = s; thr_sel = sel; qam_dpsk = md; conv_lost = cl;
  endtask

  function automatic string rand_tag();
    if (!qam_dpsk) return "R8";
    if (conv_lost) return "R6";
    if (mse_valid) return (mse < thr_of(thr_sel)) ? "R2" : "R4";
    return m_deg ? "R5" : "R9";
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog: cycles=%0d expected<=100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_sq = 0; m_deg = 0; m_cnt = 0;
    @(negedge clk); step("R1"); step("R1");
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step("R1");

    for (int s = 0; s < 4; s++) begin
      drive(1, thr_of(2'(s)) - 1'b1, 2'(s), 1, 0); step("R3");
      drive(1, thr_of(2'(s)), 2'(s), 1, 0); step("R3");
      drive(1, '0, 2'(s), 1, 0); step("R3");
    end

    drive(1, T3, 2'b00, 1, 0); step("R4");
    drive(0, '0, 2'b00, 1, 0);
    for (int i = 0; i < 3 * TICKS; i++) step("R5");
    drive(1, 16'hFFFF, 2'b00, 1, 0); step("R5");
    drive(0, 16'hFFFF, 2'b00, 1, 0);
    for (int i = 0; i < 2 * TICKS; i++) step("R9");
    drive(1, 16'h0001, 2'b00, 1, 0); step("R2");
    drive(0, '0, 2'b00, 1, 0); step("R2");

    drive(1, T3, 2'b00, 1, 0); step("R4");
    drive(0, '0, 2'b00, 1, 1);
    for (int i = 0; i < 2 * TICKS; i++) step("R6");
    drive(1, '0, 2'b00, 1, 1); step("R6");
    drive(0, '0, 2'b00, 1, 0);
    for (int i = 0; i < 2 * TICKS; i++) step("R7");
    drive(1, T5, 2'b00, 1, 0); step("R7");

    drive(1, T3, 2'b11, 0, 1);
    for (int i = 0; i < 4; i++) step("R8");
    drive(0, '0, 2'b00, 1, 0);
    for (int i = 0; i < 2 * TICKS; i++) step("R8");

    for (int i = 0; i < 4000; i++) begin
      logic [W-1:0] s;
      s = ($urandom_range(0, 1) == 1) ? W'($urandom_range(0, 16'h0A00)) : W'($urandom);
      drive($urandom_range(0, 5) == 0, s, 2'($urandom_range(0, 3)),
            $urandom_range(0, 60) != 0, $urandom_range(0, 40) == 0);
      step(rand_tag());
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule